// File: doc/BRIEF.md
# Addressed Serial DAC Register Interface

This block is the digital front end of a multi-channel 10-bit digital-to-analog converter. A host drives three serial lines: a shift clock, a data line and a load strobe. Every rising edge of the shift clock moves one data bit into a 14-bit shift register. A rising load strobe reads that register as one frame. The frame holds a 4-bit channel address and a 10-bit conversion code. The code is written into the holding register of the addressed channel. Every channel code is presented in parallel, so an analog ladder outside this block can turn it into a voltage of VrefL + (VrefH − VrefL)·code/1024.

All serial lines are sampled by a faster system clock through synchronizer stages, and edges are found in that clock domain. An order-select input sets whether the first data bit of the frame is the least or the most significant bit of the code. The address field is not affected by this input. The far end of the shift register drives a serial output, so a second device can take its frames from the first. An active-low reset clears every channel to code 0 and holds it there. A parameter sets the build to 8 or 10 channels.

Top module: `sdac_front`

## Requirements
- R1: While `rst_n` is low, every channel code on `ch_codes_o` is 0 and `ser_dat_o` is 0.
- R2: Each rising edge of `ser_clk_i` shifts `ser_dat_i` into the shift register. `ser_dat_o` shows the bit that entered 14 shift edges earlier, so the first bit sent in a frame is on `ser_dat_o` once the whole frame is in.
- R3: Frame layout, in sending order: bits 0 to 3 are the channel address, with bit 0 as its least significant bit. Bits 4 to 13 are the data field. A rising edge of `ser_ld_i` writes the decoded code into the addressed channel only.
- R4: Address value a, for 1 ≤ a ≤ NUM_CH, selects channel a−1. That channel occupies `ch_codes_o[(a−1)*10 +: 10]`. In an 8-channel build, addresses 9 and 10 select nothing.
- R5: A load with address 0, or with an address above NUM_CH (up to 15), leaves every channel code unchanged.
- R6: With `lsb_first_i` high, frame bit 4 is code bit 0 and frame bit 13 is code bit 9. With `lsb_first_i` low, frame bit 4 is code bit 9 and frame bit 13 is code bit 0. The address field reads the same in both cases.
- R7: Shifting without a load rising edge leaves every channel code unchanged.
- R8: A load pulse writes exactly once, on its rising edge. Frames shifted in while the load line stays high are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low asynchronous reset; clears all channels |
| ser_clk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data input |
| ser_ld_i | input | 1 | Load strobe; a rising edge writes the current frame |
| lsb_first_i | input | 1 | Data field order: 1 = first data bit is the LSB, 0 = first data bit is the MSB |
| ser_dat_o | output | 1 | Far end of the shift register, for chaining to another device |
| ch_codes_o | output | NUM_CH*10 | Channel codes, channel k in bits [k*10 +: 10] |

## Verification
The assertions assume the serial lines change slowly compared with the system clock. Each level of the shift clock and the load strobe is taken to last longer than the synchronizer depth plus one cycle. The data line and the order select are taken to be steady around the shift and load edges that use them. The stimulus holds every serial level for four system clocks. It changes the data line and the order select only while the shift clock is low and the load line is low. Under these conditions each serial edge gives exactly one detected pulse, and the properties on shifting, writing and holding apply cycle by cycle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int ADDR_W  = 4;
   localparam int CODE_W  = 10;
   localparam int FRAME_W = ADDR_W + CODE_W;

   typedef logic [ADDR_W-1:0]  addr_t;
   typedef logic [CODE_W-1:0]  code_t;
   typedef logic [FRAME_W-1:0] frame_t;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } order_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sdac_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sdac_sync: W must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
   parameter int LEN = sdac_pkg::FRAME_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           din,
   output logic [LEN-1:0] frame,
   output logic           dout
);
   // New bits enter at the top, so the first bit sent ends up at index 0.
   logic [LEN-1:0] sr;

   generate
      if (LEN < 2) begin : g_bad_len
         $error("sdac_shreg: LEN must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sr <= '0;
      else if (en) sr <= {din, sr[LEN-1:1]};
   end

   assign frame = sr;
   assign dout  = sr[0];
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
   import sdac_pkg::*;
#(
   parameter int NUM_CH = 10
) (
   input  frame_t            frame,
   input  logic              lsb_first,
   input  logic              strobe,
   output addr_t             addr,
   output code_t             code,
   output logic [NUM_CH-1:0] wr_en
);
   code_t field;
   code_t field_rev;

   assign addr  = frame[ADDR_W-1:0];
   assign field = frame[FRAME_W-1:ADDR_W];

   generate
      for (genvar i = 0; i < CODE_W; i++) begin : g_rev
         assign field_rev[i] = field[CODE_W-1-i];
      end
   endgenerate

   assign code = (order_e'(lsb_first) == ORDER_LSB_FIRST) ? field : field_rev;

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
         assign wr_en[k] = strobe && (addr == ADDR_W'(k + 1));
      end
   endgenerate
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank
   import sdac_pkg::*;
#(
   parameter int NUM_CH = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        wr_en,
   input  code_t                    code,
   output logic [NUM_CH*CODE_W-1:0] codes
);
   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         code_t hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hold_q <= '0;
            else if (wr_en[k]) hold_q <= code;
         end
         assign codes[k*CODE_W +: CODE_W] = hold_q;
      end
   endgenerate
endmodule

// File: rtl/sdac_front.sv
module sdac_front
   import sdac_pkg::*;
#(
   parameter int NUM_CH      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_clk_i,
   input  logic                     ser_dat_i,
   input  logic                     ser_ld_i,
   input  logic                     lsb_first_i,
   output logic                     ser_dat_o,
   output logic [NUM_CH*CODE_W-1:0] ch_codes_o
);
   localparam int          LINES    = 4;
   localparam logic [3:0]  LINE_RST = 4'b1000; // order line idles at LSB-first

   generate
      if (!(NUM_CH == 8 || NUM_CH == 10)) begin : g_bad_ch
         $error("sdac_front: NUM_CH must be 8 or 10");
      end
   endgenerate

   logic [LINES-1:0] lines_raw;
   logic [LINES-1:0] lines_s;
   logic             sck_s, dat_s, ld_s, ord_s;
   logic [1:0]       edge_prev;
   logic             sclk_rise, load_rise;
   frame_t           shreg;
   addr_t            dec_addr;
   code_t            dec_code;
   logic [NUM_CH-1:0] wr_en;

   assign lines_raw = {lsb_first_i, ser_ld_i, ser_dat_i, ser_clk_i};

   sdac_sync #(
      .W       (LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (LINE_RST)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lines_raw),
      .q     (lines_s)
   );

   assign {ord_s, ld_s, dat_s, sck_s} = lines_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_prev <= '0;
      else        edge_prev <= {ld_s, sck_s};
   end

   assign sclk_rise = sck_s & ~edge_prev[0];
   assign load_rise = ld_s  & ~edge_prev[1];

   sdac_shreg #(
      .LEN (FRAME_W)
   ) shreg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sclk_rise),
      .din   (dat_s),
      .frame (shreg),
      .dout  (ser_dat_o)
   );

   sdac_decode #(
      .NUM_CH (NUM_CH)
   ) dec_i (
      .frame     (shreg),
      .lsb_first (ord_s),
      .strobe    (load_rise),
      .addr      (dec_addr),
      .code      (dec_code),
      .wr_en     (wr_en)
   );

   sdac_bank #(
      .NUM_CH (NUM_CH)
   ) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .code  (dec_code),
      .codes (ch_codes_o)
   );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
   import sdac_pkg::*;
#(
   parameter int NUM_CH = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_CH*CODE_W-1:0] codes,
   input logic                     sdo,
   input logic                     sclk_rise,
   input logic                     load_rise,
   input logic                     sr_b1,
   input addr_t                    addr,
   input code_t                    code_word
);
   // R1: reset holds all codes and the chain output at zero
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (codes == '0 && sdo == 1'b0));

   // R2: a shift edge moves the next bit to the chain output
   assert_shift_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> sdo == $past(sr_b1));

   // R2: no shift edge, no change on the chain output
   assert_sdo_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(sdo));

   // R5: ignored addresses leave every channel alone
   assert_bad_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_rise && (addr == '0 || int'(addr) > NUM_CH)) |=> $stable(codes));

   // R7: channels hold without a load edge
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_rise |=> $stable(codes));

   // R8: a detected load edge is a single-cycle event
   assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise |=> !load_rise);

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_wr
         // R3 / R4: addressed channel takes the decoded code
         assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (load_rise && addr == ADDR_W'(k + 1)) |=>
               codes[k*CODE_W +: CODE_W] == $past(code_word));
      end
   endgenerate
endmodule

bind sdac_front sdac_front_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .codes     (ch_codes_o),
   .sdo       (ser_dat_o),
   .sclk_rise (sclk_rise),
   .load_rise (load_rise),
   .sr_b1     (shreg[1]),
   .addr      (dec_addr),
   .code_word (dec_code)
);

// File: tb/sdac_front_tb_top.sv
module sdac_front_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH     = 10;
   localparam int CW         = 10;
   localparam int HOLD       = 4;
   localparam int WDOG       = 150000;
   localparam int NVEC       = 14;

   // {lsb_first, addr[3:0], field as sent (bit0 first)[9:0], expected code[9:0]}
   localparam logic [24:0] VECS [NVEC] = '{
      {1'b1, 4'd1,  10'h001, 10'h001},
      {1'b0, 4'd2,  10'h001, 10'h200},
      {1'b1, 4'd3,  10'h3FF, 10'h3FF},
      {1'b0, 4'd4,  10'h3FF, 10'h3FF},
      {1'b1, 4'd5,  10'h155, 10'h155},
      {1'b0, 4'd6,  10'h155, 10'h2AA},
      {1'b1, 4'd7,  10'h0F0, 10'h0F0},
      {1'b0, 4'd8,  10'h003, 10'h300},
      {1'b1, 4'd9,  10'h123, 10'h123},
      {1'b0, 4'd10, 10'h001, 10'h200},
      {1'b1, 4'd0,  10'h3FF, 10'h000},
      {1'b1, 4'd11, 10'h2AA, 10'h000},
      {1'b1, 4'd15, 10'h111, 10'h000},
      {1'b1, 4'd1,  10'h000, 10'h000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic ser_clk = 1'b0;
   logic ser_dat = 1'b0;
   logic ser_ld = 1'b0;
   logic lsb_first = 1'b1;
   logic ser_dat_o;
   logic [NUM_CH*CW-1:0] ch_codes;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [CW-1:0] shadow [NUM_CH];

   always #(CLK_PERIOD/2) clk = ~clk;

   sdac_front #(.NUM_CH(NUM_CH)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_clk_i   (ser_clk),
      .ser_dat_i   (ser_dat),
      .ser_ld_i    (ser_ld),
      .lsb_first_i (lsb_first),
      .ser_dat_o   (ser_dat_o),
      .ch_codes_o  (ch_codes)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b;
      wait_clk(HOLD);
      ser_clk = 1'b1;
      wait_clk(HOLD);
      ser_clk = 1'b0;
      wait_clk(HOLD);
   endtask

   task automatic send_frame(input logic [3:0] a, input logic [9:0] f);
      for (int i = 0; i < 4; i++)  send_bit(a[i]);
      for (int i = 0; i < 10; i++) send_bit(f[i]);
   endtask

   task automatic pulse_load();
      ser_ld = 1'b1;
      wait_clk(HOLD);
      ser_ld = 1'b0;
      wait_clk(HOLD + 2);
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      bit bad = 1'b0;
      checks++;
      for (int k = 0; k < NUM_CH; k++) begin
         if (ch_codes[k*CW +: CW] !== shadow[k]) begin
            bad = 1'b1;
            $display("FAIL %s: channel %0d actual %03h expected %03h",
                     tag, k, ch_codes[k*CW +: CW], shadow[k]);
         end
      end
      if (bad) fails++;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      for (int k = 0; k < NUM_CH; k++) shadow[k] = '0;
      #1 rst_n = 1'b0;
      wait_clk(3);
      // R1: reset state
      check_all("R1 reset codes");
      check_bit("R1 reset sdo", ser_dat_o, 1'b0);
      rst_n = 1'b1;
      wait_clk(3);

      // Vector table: R3, R4, R5, R6
      for (int v = 0; v < NVEC; v++) begin
         logic       ord;
         logic [3:0] a;
         logic [9:0] f, e;
         string      tag;
         {ord, a, f, e} = VECS[v];
         lsb_first = ord;
         wait_clk(HOLD);
         send_frame(a, f);
         pulse_load();
         if (a == 4'd0 || int'(a) > NUM_CH) tag = "R5 ignored address";
         else begin
            shadow[a-1] = e;
            if (!ord)          tag = "R6 msb-first order";
            else if (a >= 4'd9) tag = "R4 upper channel";
            else               tag = "R3 write";
         end
         check_all(tag);
      end
      lsb_first = 1'b1;

      // R2: chain output shows the first bit of the frame, then the next ones
      send_frame(4'd5, 10'h2C7);
      check_bit("R2 sdo bit0", ser_dat_o, 1'b1);
      send_bit(1'b0);
      check_bit("R2 sdo bit1", ser_dat_o, 1'b0);
      send_bit(1'b0);
      check_bit("R2 sdo bit2", ser_dat_o, 1'b1);

      // R7: a full frame shifted without load changes nothing
      send_frame(4'd2, 10'h3FF);
      check_all("R7 hold without load");

      // R8: frame shifted under a held load is not written
      send_frame(4'd3, 10'h0AA);
      ser_ld = 1'b1;
      wait_clk(HOLD);
      send_frame(4'd3, 10'h3C3);
      ser_ld = 1'b0;
      wait_clk(HOLD + 2);
      shadow[2] = 10'h0AA;
      check_all("R8 single write per pulse");

      // R1: reset in mid run clears every channel while held
      rst_n = 1'b0;
      wait_clk(2);
      for (int k = 0; k < NUM_CH; k++) shadow[k] = '0;
      check_all("R1 mid-run reset");
      check_bit("R1 mid-run sdo", ser_dat_o, 1'b0);
      rst_n = 1'b1;
      wait_clk(3);
      check_all("R1 after release");

      finish_run();
   end
endmodule